// File: doc/BRIEF.md
# Free-to-Sample Itemset Expander

The expander maps a point of the reduced search space back into the full item alphabet. A small set of parity constraints has been brought into reduced echelon form. Every active row owns one pivot item, and that item appears in no other active row. Each item that is not a pivot is a free item. When the expander is given a choice of free items, it fills in every pivot item so that all constraints hold. The result is the one full itemset that belongs to that choice. A search that walks only the free alphabet therefore visits each constraint-satisfying sample exactly once.

A second mode tests an arbitrary full itemset against the same constraints and returns one pass/fail bit. Items are bit positions of an `N`-bit vector, with item 0 at bit 0. Each of the `K` row slots carries a coefficient vector, a pivot index, a parity bit and an enable. The enabled rows must have distinct pivots. The result is registered one cycle after the request. A small state machine tracks what the output register holds. Its states are `ST_IDLE` (nothing valid), `ST_EXPANDED` (an expansion result) and `ST_CHECKED` (a check result). From any state the next state is chosen by the current request: no request goes to `ST_IDLE`, an expand request goes to `ST_EXPANDED`, and a check request goes to `ST_CHECKED`.

Top module: `ftse_expander`

## Requirements
- R1: After reset, `out_valid`, `out_items` and `out_pass` are all 0.
- R2: A cycle with `in_valid`=1 makes `out_valid`=1 on the next cycle. A cycle with `in_valid`=0 makes `out_valid`=0 on the next cycle.
- R3: In expand mode (`mode`=0), the output bit at the pivot of each enabled row is computed as follows. Take the XOR of `item_in` at every free position above the pivot where the row's coefficient is 1, then XOR that with the row's parity bit.
- R4: Some row coefficient bits are ignored in expansion: bits at or below the row's own pivot, and bits at the pivot of any other enabled row.
- R5: In expand mode, every free position of `out_items` equals `item_in`. The `item_in` bits at pivot positions have no effect on the output.
- R6: Rows with enable 0 have no effect. With no row enabled, `out_items` equals `item_in` in both modes, and `out_pass` is 1.
- R7: In check mode (`mode`=1), `out_items` equals `item_in`. `out_pass` is 1 only when every enabled row meets this condition: `item_in` at its pivot, XOR the parity over the free positions above the pivot selected by its coefficients, equals its parity bit. For example, take items a..f at bits 0..5, with row pivot a, coefficients {c,e}, parity 1, and row pivot b, coefficients {e,f}, parity 0. Then abde fails and abdf passes.
- R8: In expand mode, `out_pass` is 1. Any expanded itemset passes check mode under the same rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| mode | input | 1 | 0 = expand, 1 = check |
| item_in | input | N | Free itemset (expand) or full itemset (check) |
| row_en | input | K | Enable per row slot |
| row_pivot | input | K*$clog2(N) | Pivot index per row, row k at bits [k*PW +: PW] |
| row_coef | input | K*N | Coefficients per row, row k at bits [k*N +: N] |
| row_parity | input | K | Parity bit per row |
| out_valid | output | 1 | Result valid |
| out_items | output | N | Expanded or echoed itemset |
| out_pass | output | 1 | Check result (1 in expand mode) |

## Verification
The bench builds the expander with N=6 and K=3. That makes the whole 64-entry item space small enough to sweep in both modes, for each of four row configurations. The configurations are: no rows enabled, the two-row example, a three-row set whose coefficients are full of bits below pivots and at other pivots, and the example with a third row that is disabled but carries garbage. Each expansion is also fed back through check mode, which exercises the round trip that the one-to-one mapping promises.

// File: rtl/ftse_pkg.sv
package ftse_pkg;
    typedef enum logic {
        MODE_EXPAND = 1'b0,
        MODE_CHECK  = 1'b1
    } ftse_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_EXPANDED = 2'd1,
        ST_CHECKED  = 2'd2
    } ftse_state_e;
endpackage

// File: rtl/ftse_pivmask.sv
// Marks every item position that is the pivot of an enabled row.
module ftse_pivmask #(
    parameter int N  = 8,
    parameter int K  = 4,
    parameter int PW = 3
) (
    input  logic [K-1:0]    row_en,
    input  logic [K*PW-1:0] row_pivot,
    output logic [N-1:0]    pivot_mask
);
    always_comb begin
        pivot_mask = '0;
        for (int k = 0; k < K; k++) begin
            if (row_en[k] && (int'(row_pivot[k*PW +: PW]) < N))
                pivot_mask[row_pivot[k*PW +: PW]] = 1'b1;
        end
    end
endmodule

// File: rtl/ftse_row.sv
// One reduced constraint row: pivot value in expand mode, pass bit in check mode.
module ftse_row #(
    parameter int N  = 8,
    parameter int PW = 3
) (
    input  logic          en,
    input  logic [PW-1:0] pivot,
    input  logic [N-1:0]  coef,
    input  logic          parity,
    input  logic [N-1:0]  items,
    input  logic [N-1:0]  free_mask,
    output logic [N-1:0]  pivot_oh,
    output logic          pivot_val,
    output logic          row_ok
);
    logic [N-1:0] above;

    always_comb begin
        above    = '0;
        pivot_oh = '0;
        for (int i = 0; i < N; i++)
            above[i] = (i > int'(pivot));
        if (en && (int'(pivot) < N))
            pivot_oh[pivot] = 1'b1;
        pivot_val = parity ^ (^(coef & items & free_mask & above));
        row_ok    = !en || ((|(items & pivot_oh)) == pivot_val);
    end
endmodule

// File: rtl/ftse_expander.sv
module ftse_expander
    import ftse_pkg::*;
#(
    parameter int N = 8,
    parameter int K = 4,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            mode,
    input  logic [N-1:0]    item_in,
    input  logic [K-1:0]    row_en,
    input  logic [K*PW-1:0] row_pivot,
    input  logic [K*N-1:0]  row_coef,
    input  logic [K-1:0]    row_parity,
    output logic            out_valid,
    output logic [N-1:0]    out_items,
    output logic            out_pass
);
    logic [N-1:0] piv_mask;
    logic [N-1:0] row_oh  [K];
    logic [K-1:0] row_bit;
    logic [K-1:0] row_ok;
    logic [N-1:0] expanded;
    logic         all_ok;
    ftse_mode_e   req_mode;
    ftse_state_e  state_q, state_d;
    logic [N-1:0] items_q;
    logic         pass_q;

    assign req_mode = ftse_mode_e'(mode);

    ftse_pivmask #(.N(N), .K(K), .PW(PW)) u_mask (
        .row_en     (row_en),
        .row_pivot  (row_pivot),
        .pivot_mask (piv_mask)
    );

    for (genvar g = 0; g < K; g++) begin : g_row
        ftse_row #(.N(N), .PW(PW)) u_row (
            .en        (row_en[g]),
            .pivot     (row_pivot[g*PW +: PW]),
            .coef      (row_coef[g*N +: N]),
            .parity    (row_parity[g]),
            .items     (item_in),
            .free_mask (~piv_mask),
            .pivot_oh  (row_oh[g]),
            .pivot_val (row_bit[g]),
            .row_ok    (row_ok[g])
        );
    end

    always_comb begin
        expanded = item_in & ~piv_mask;
        for (int k = 0; k < K; k++)
            expanded = expanded | (row_oh[k] & {N{row_bit[k]}});
        all_ok = &row_ok;
    end

    // next-state choice
    always_comb begin
        state_d = ST_IDLE;
        if (in_valid)
            state_d = (req_mode == MODE_CHECK) ? ST_CHECKED : ST_EXPANDED;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            items_q <= '0;
            pass_q  <= 1'b0;
        end else if (in_valid) begin
            if (req_mode == MODE_CHECK) begin
                items_q <= item_in;
                pass_q  <= all_ok;
            end else begin
                items_q <= expanded;
                pass_q  <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:     out_valid = 1'b0;
            ST_EXPANDED: out_valid = 1'b1;
            ST_CHECKED:  out_valid = 1'b1;
            default:     out_valid = 1'b0;
        endcase
        out_items = items_q;
        out_pass  = pass_q;
    end
endmodule

// File: rtl/ftse_expander_chk.sv
module ftse_expander_chk #(
    parameter int N = 8,
    parameter int K = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         mode,
    input logic [N-1:0] item_in,
    input logic [K-1:0] row_en,
    input logic [N-1:0] piv_mask,
    input logic         out_valid,
    input logic [N-1:0] out_items,
    input logic         out_pass
);
    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_FREE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode) |=> (((out_items ^ $past(item_in)) & ~$past(piv_mask)) == '0)); // R5
    AST_NO_ROWS_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (row_en == '0)) |=> (out_items == $past(item_in))); // R6
    AST_EMPTY_CHECK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode && (row_en == '0)) |=> out_pass); // R6
    AST_CHECK_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode) |=> (out_items == $past(item_in))); // R7
    AST_EXPAND_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode) |=> out_pass); // R8
endmodule

bind ftse_expander ftse_expander_chk #(.N(N), .K(K)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .item_in   (item_in),
    .row_en    (row_en),
    .piv_mask  (piv_mask),
    .out_valid (out_valid),
    .out_items (out_items),
    .out_pass  (out_pass)
);

// File: tb/ftse_expander_bench.sv
`timescale 1ns/1ps
module ftse_expander_bench;
    localparam int N  = 6;
    localparam int K  = 3;
    localparam int PW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            mode = 1'b0;
    logic [N-1:0]    item_in = '0;
    logic [K-1:0]    row_en;
    logic [K*PW-1:0] row_pivot;
    logic [K*N-1:0]  row_coef;
    logic [K-1:0]    row_parity;
    logic            out_valid;
    logic [N-1:0]    out_items;
    logic            out_pass;

    logic [N-1:0]  c_coef [K];
    logic [PW-1:0] c_piv  [K];
    logic [K-1:0]  c_par;
    logic [K-1:0]  c_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    for (genvar g = 0; g < K; g++) begin : g_pack
        assign row_coef[g*N +: N]    = c_coef[g];
        assign row_pivot[g*PW +: PW] = c_piv[g];
    end
    assign row_parity = c_par;
    assign row_en     = c_en;

    ftse_expander #(.N(N), .K(K)) u_ftse_expander (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .item_in(item_in), .row_en(row_en), .row_pivot(row_pivot),
        .row_coef(row_coef), .row_parity(row_parity),
        .out_valid(out_valid), .out_items(out_items), .out_pass(out_pass)
    );

    function automatic logic [N-1:0] m_pivots();
        logic [N-1:0] m = '0;
        for (int k = 0; k < K; k++) if (c_en[k]) m[c_piv[k]] = 1'b1;
        return m;
    endfunction

    // parity of the row's selected free items strictly above its pivot
    function automatic logic m_sum(int k, logic [N-1:0] v);
        logic s = 1'b0;
        logic [N-1:0] pm = m_pivots();
        for (int i = 0; i < N; i++)
            if (i > int'(c_piv[k]) && c_coef[k][i] && !pm[i]) s = s ^ v[i];
        return s;
    endfunction

    function automatic logic [N-1:0] m_expand(logic [N-1:0] v);
        logic [N-1:0] r = v;
        for (int k = 0; k < K; k++)
            if (c_en[k]) r[c_piv[k]] = c_par[k] ^ m_sum(k, v);
        return r;
    endfunction

    function automatic logic m_pass(logic [N-1:0] v);
        logic ok = 1'b1;
        for (int k = 0; k < K; k++)
            if (c_en[k] && ((v[c_piv[k]] ^ m_sum(k, v)) != c_par[k])) ok = 1'b0;
        return ok;
    endfunction

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic request(logic m, logic [N-1:0] v);
        @(negedge clk);
        in_valid = 1'b1;
        mode     = m;
        item_in  = v;
        @(posedge clk);
        #1;
        check("R2 valid", {{(N-1){1'b0}}, out_valid}, {{(N-1){1'b0}}, 1'b1});
    endtask

    task automatic sweep(string tag);
        for (int v = 0; v < (1 << N); v++) begin
            logic [N-1:0] vin = N'(v);
            logic [N-1:0] e = m_expand(vin);
            logic [N-1:0] fm = ~m_pivots();
            request(1'b0, vin);
            check({tag, " expand"}, out_items, e);
            check("R5 free copy", out_items & fm, vin & fm);
            check("R8 expand pass", {{(N-1){1'b0}}, out_pass}, {{(N-1){1'b0}}, 1'b1});
            request(1'b1, vin);
            check("R7 check echo", out_items, vin);
            check({tag, " R7 check pass"}, {{(N-1){1'b0}}, out_pass},
                  {{(N-1){1'b0}}, m_pass(vin)});
            request(1'b1, e);
            check("R8 round trip", {{(N-1){1'b0}}, out_pass}, {{(N-1){1'b0}}, 1'b1});
        end
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R2 idle", {{(N-1){1'b0}}, out_valid}, '0);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            report();
        end
    end

    initial begin
        for (int k = 0; k < K; k++) begin
            c_coef[k] = '1;
            c_piv[k]  = PW'(k);
        end
        c_par = '1;
        c_en  = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset items", out_items, '0);
        check("R1 reset flags", {{(N-2){1'b0}}, out_valid, out_pass}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // no rows enabled, garbage coefficients: identity
        sweep("R6 no rows");

        // example rows: pivot a {c,e} par 1; pivot b {e,f} par 0
        c_en = 3'b011;
        c_piv[0] = 3'd0; c_coef[0] = 6'b010100; c_par[0] = 1'b1;
        c_piv[1] = 3'd1; c_coef[1] = 6'b110000; c_par[1] = 1'b0;
        request(1'b1, 6'b011011);
        check("R7 abde fails", {{(N-1){1'b0}}, out_pass}, '0);
        request(1'b1, 6'b101011);
        check("R7 abdf passes", {{(N-1){1'b0}}, out_pass}, {{(N-1){1'b0}}, 1'b1});
        sweep("R3 example");

        // same, plus a disabled row full of garbage
        c_piv[2] = 3'd2; c_coef[2] = '1; c_par[2] = 1'b1;
        sweep("R6 disabled row");

        // coefficient bits below pivot and at other pivots must be ignored
        c_en = 3'b111;
        c_piv[0] = 3'd1; c_coef[0] = 6'b011111; c_par[0] = 1'b0;
        c_piv[1] = 3'd3; c_coef[1] = 6'b101000; c_par[1] = 1'b1;
        c_piv[2] = 3'd4; c_coef[2] = 6'b110010; c_par[2] = 1'b0;
        sweep("R4 ignored bits");

        done = 1'b1;
        report();
    end
endmodule